// File: doc/BRIEF.md
# Odd-Multiple Table Constant Multiplier

This block multiplies an unsigned input word by a coefficient that is fixed when the block is built. It does not store every product. It keeps only the odd multiples of the coefficient in a small table, plus one word that reads as zero. An even product is the product of an odd part and a power of two, so the block rebuilds it by shifting the matching odd multiple to the left.

For each input word, an encoder finds the number of trailing zero bits. It then strips those zeros and the lowest one bit to form the table index. The trailing-zero count drives a left barrel shifter. An input of zero selects the zero word with no shift. The table contents are computed from the coefficient parameter when the design is elaborated, and the product is held in an output register.

Both data sides use a valid/ready handshake. A word moves when valid and ready are high on the same rising clock edge. The output register is the only storage stage. The input is ready whenever that register is empty or is being drained in the same cycle. While the output is held (valid high and ready low), the input is not ready and the held product does not change.

Top module: `oms_const_mult`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` is 0 and `in_ready` is 1.
- R2: An accepted odd input X produces `out_data` equal to COEF·X, zero-extended to W_COEF+L_IN bits.
- R3: An accepted input of 0 produces `out_data` equal to 0.
- R4: An accepted even nonzero input X = (2i+1)·2^s produces COEF·X. The value comes from the odd multiple COEF·(2i+1) shifted left by s, where s ≤ L_IN−1.
- R5: A word accepted at a rising edge appears on `out_valid`/`out_data` after that same edge, with one cycle of latency.
- R6: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_data` keeps its value.
- R7: If `out_ready` is 1 and no word is accepted, `out_valid` is 0 after the next edge.
- R8: With the largest input (all ones) and the largest coefficient (all ones), the full product is delivered and no bit is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | L_IN | Unsigned multiplicand |
| out_valid | output | 1 | Product register holds a result |
| out_ready | input | 1 | Consumer takes the product |
| out_data | output | W_COEF+L_IN | Product COEF·in_data |

## Verification
The hardest case to reach from the ports is a stalled product while a different word waits at the input. In that case the register must keep the old product and must not take the waiting word. The stimulus holds `out_ready` low for two cycles with a new word already valid. It checks that the old product stays and the input is refused, and then checks that the waiting word passes once `out_ready` returns. Every shift amount and every table word is reached by sweeping all input values through three builds of the block. The coefficients are odd, even, and all ones, so the widest product is also covered.

// File: rtl/oms_pkg.sv
package oms_pkg;
  // Number of odd multiples kept for an input of the given width
  function automatic int odd_count(input int in_w);
    return 1 << (in_w - 1);
  endfunction

  // Shift-select width for a maximum left shift of in_w-1
  function automatic int shift_bits(input int in_w);
    return (in_w > 2) ? $clog2(in_w) : 1;
  endfunction
endpackage

// File: rtl/oms_addr_enc.sv
module oms_addr_enc #(
  parameter int L_IN  = 4,
  parameter int AW    = 4,
  parameter int SW    = 2,
  parameter int ODD_N = 8
) (
  input  logic [L_IN-1:0] x,
  output logic [AW-1:0]   addr,
  output logic [SW-1:0]   shamt
);
  logic            found;
  logic [L_IN-1:0] norm;

  // trailing-zero count, lowest set bit wins
  always_comb begin
    shamt = '0;
    found = 1'b0;
    for (int k = 0; k < L_IN; k++) begin
      if (!found && x[k]) begin
        shamt = SW'(k);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    norm = x >> shamt;
    if (found) addr = AW'(norm[L_IN-1:1]);
    else       addr = AW'(ODD_N);
  end

  always_comb begin
    // R4
    odd_noshift_chk: assert (!x[0] || shamt == '0);
    // R4
    shift_range_chk: assert (int'(shamt) <= L_IN - 1);
    // R3
    zero_sel_chk: assert (x != '0 || (addr == AW'(ODD_N) && shamt == '0));
  end
endmodule

// File: rtl/oms_odd_table.sv
module oms_odd_table #(
  parameter int               L_IN   = 4,
  parameter int               W_COEF = 8,
  parameter logic [W_COEF-1:0] COEF  = 8'd13,
  parameter int               AW     = 4,
  parameter int               PW     = 12,
  parameter int               ODD_N  = 8
) (
  input  logic [AW-1:0] addr,
  output logic [PW-1:0] word
);
  localparam int DEPTH = ODD_N + 1;

  logic [PW-1:0] rom [DEPTH];

  // contents fixed at elaboration: odd multiples, then the zero word
  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    if (g < ODD_N) begin : g_odd
      localparam logic [PW-1:0] VAL = PW'(COEF) * PW'(2 * g + 1);
      assign rom[g] = VAL;
    end else begin : g_zero
      assign rom[g] = '0;
    end
  end

  always_comb begin
    word = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (addr == AW'(k)) word = rom[k];
    end
  end
endmodule

// File: rtl/oms_barrel_shl.sv
module oms_barrel_shl #(
  parameter int PW = 12,
  parameter int SW = 2
) (
  input  logic [PW-1:0] din,
  input  logic [SW-1:0] shamt,
  output logic [PW-1:0] dout
);
  logic [PW-1:0] stage [SW+1];

  assign stage[0] = din;

  // one stage per shift-select bit, stage k shifts by 2^k
  for (genvar s = 0; s < SW; s++) begin : g_stage
    assign stage[s+1] = shamt[s] ? (stage[s] << (1 << s)) : stage[s];
  end

  assign dout = stage[SW];

  always_comb begin
    // R2
    pass_thru_chk: assert (shamt != '0 || dout == din);
  end
endmodule

// File: rtl/oms_const_mult.sv
module oms_const_mult #(
  parameter int                L_IN   = 4,
  parameter int                W_COEF = 8,
  parameter logic [W_COEF-1:0] COEF   = 8'd13
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [L_IN-1:0]        in_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [W_COEF+L_IN-1:0] out_data
);
  import oms_pkg::*;

  localparam int PW    = W_COEF + L_IN;
  localparam int ODD_N = odd_count(L_IN);
  localparam int DEPTH = ODD_N + 1;
  localparam int AW    = $clog2(DEPTH);
  localparam int SW    = shift_bits(L_IN);

  logic [AW-1:0] tbl_addr;
  logic [SW-1:0] tbl_shift;
  logic [PW-1:0] odd_word;
  logic [PW-1:0] product;
  logic          accept;

  oms_addr_enc #(.L_IN(L_IN), .AW(AW), .SW(SW), .ODD_N(ODD_N)) enc_i (
    .x(in_data), .addr(tbl_addr), .shamt(tbl_shift)
  );

  oms_odd_table #(.L_IN(L_IN), .W_COEF(W_COEF), .COEF(COEF), .AW(AW),
                  .PW(PW), .ODD_N(ODD_N)) tbl_i (
    .addr(tbl_addr), .word(odd_word)
  );

  oms_barrel_shl #(.PW(PW), .SW(SW)) shl_i (
    .din(odd_word), .shamt(tbl_shift), .dout(product)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (accept) out_data <= product;
    end
  end

  // R5
  accept_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R7
  idle_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && out_ready |=> !out_valid);
  // R3
  zero_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_data == '0 |=> out_data == '0);
endmodule

// File: tb/oms_const_mult_tb.sv
`timescale 1ns/1ps
module oms_const_mult_tb_top;
  localparam int L  = 4;
  localparam int W  = 8;
  localparam int PW = W + L;
  localparam int NV = 8;

  localparam logic [L-1:0]  VX [NV] = '{4'd0, 4'd1, 4'd2, 4'd4, 4'd8, 4'd12, 4'd6, 4'd15};
  localparam logic [PW-1:0] VP [NV] = '{12'd0, 12'd13, 12'd26, 12'd52, 12'd104, 12'd156, 12'd78, 12'd195};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [L-1:0] in_data = '0;
  logic rdy_a, rdy_b, rdy_c, val_a, val_b, val_c;
  logic [PW-1:0] dat_a, dat_b, dat_c;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  oms_const_mult #(.L_IN(L), .W_COEF(W), .COEF(8'd13)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_a),
    .in_data(in_data), .out_valid(val_a), .out_ready(out_ready), .out_data(dat_a));
  oms_const_mult #(.L_IN(L), .W_COEF(W), .COEF(8'd255)) dut_max (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_b),
    .in_data(in_data), .out_valid(val_b), .out_ready(out_ready), .out_data(dat_b));
  oms_const_mult #(.L_IN(L), .W_COEF(W), .COEF(8'd6)) dut_even (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_c),
    .in_data(in_data), .out_valid(val_c), .out_ready(out_ready), .out_data(dat_c));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", int'(val_a), 0);
    chk("R1 ready in reset", int'(rdy_a), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", int'(val_a), 0);

    // vector table, streamed back to back
    for (int v = 0; v < NV; v++) begin
      in_valid = 1'b1;
      in_data  = VX[v];
      @(negedge clk);
      chk("R5 valid", int'(val_a), 1);
      if (VX[v] == 0)      chk("R3 zero", int'(dat_a), int'(VP[v]));
      else if (VX[v][0])   chk("R2 odd", int'(dat_a), int'(VP[v]));
      else                 chk("R4 even", int'(dat_a), int'(VP[v]));
    end

    // full sweep on three coefficients
    for (int x = 0; x < (1 << L); x++) begin
      in_data = L'(x);
      @(negedge clk);
      chk("R2 sweep c13", int'(dat_a), x * 13);
      chk("R4 sweep c6", int'(dat_c), x * 6);
      if (x == (1 << L) - 1) chk("R8 widest", int'(dat_b), x * 255);
      else                   chk("R2 sweep c255", int'(dat_b), x * 255);
    end

    // idle drains the register
    in_valid = 1'b0;
    @(negedge clk);
    chk("R7 drained", int'(val_a), 0);

    // back-pressure with a waiting word
    in_valid = 1'b1;
    in_data  = 4'd5;
    @(negedge clk);
    chk("R5 stall setup", int'(dat_a), 65);
    out_ready = 1'b0;
    in_data   = 4'd9;
    @(negedge clk);
    chk("R6 hold data", int'(dat_a), 65);
    chk("R6 input blocked", int'(rdy_a), 0);
    @(negedge clk);
    chk("R6 hold data 2", int'(dat_a), 65);
    chk("R6 still valid", int'(val_a), 1);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R5 after stall", int'(dat_a), 117);
    in_valid = 1'b0;

    // reset while holding a result
    rst_n = 1'b0;
    #1;
    chk("R1 async clear", int'(val_a), 0);
    chk("R1 ready", int'(rdy_a), 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule